// File: doc/BRIEF.md
# Power-Up Configuration Phase Sequencer

This block steps a programmable device through its start-up phases once supply power is good. It first holds a power-on-reset interval whose length is picked by a select pin. It then lets go of the open-drain config-request line and waits until an external pull-up brings that line high. During the configuration phase it emits a configuration clock enable at one of two rates. When the data path reports that all configuration data has moved, it lets go of the open-drain config-done line. It reaches the initialization phase only after it senses that line high.

Every open-drain line is a pair of signals: a "pull low" output from the block and the sensed level of the line as an input. Other parties on the board may hold a line low to delay progress. If config-done stays low longer than a set number of cycles after release, the block pulls the status line low and parks in an error phase. Dropping power-good at any time restarts the sequence from the power-on-reset phase.

Top module: `cfg_phase_seq`

## Requirements
- R1: While `phase` is 0 (power-on reset), `req_pull_low`, `status_pull_low` and `done_pull_low` are all 1 and `cclk_tick` is 0. Reset puts the block in phase 0.
- R2: The power-on-reset phase lasts exactly POR_SHORT_CYC cycles when `por_short_sel` is 1 and POR_LONG_CYC cycles when it is 0. The pin is sampled on the first clock edge of the phase.
- R3: After the power-on-reset phase, `phase` is 1 and `req_pull_low` is 0. The block stays in phase 1 while `req_line_in` is low. It moves to phase 2 (configuration) on the clock edge where it samples `req_line_in` high.
- R4: In phase 2, `cclk_tick` pulses once every DIV_FAST cycles if `fast_sel` was 1 on the entry edge, and once every DIV_NORMAL cycles otherwise. The first pulse comes on the DIV-th cycle of the phase. `cclk_tick` is 0 in every other phase.
- R5: `done_pull_low` is 1 until the phase-2 edge that samples `xfer_done` high. That edge moves the block to phase 3 (wait for config-done), where `done_pull_low` is 0.
- R6: In phase 3, the edge that samples `done_line_in` high moves the block to phase 4 (initialization). Phase 4 keeps `status_pull_low` at 0 and holds while power stays good.
- R7: If `done_line_in` stays low for DONE_TIMEOUT cycles of phase 3, the block moves to phase 5 (error) with `status_pull_low` at 1.
- R8: A clock edge that samples `pwr_good` low puts the block in phase 0 with its interval counter cleared, whatever the phase before.
- R9: Changes on `fast_sel` after the entry edge of phase 2 have no effect on the `cclk_tick` spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply good; low restarts the sequence |
| por_short_sel | input | 1 | 1 selects the short power-on-reset interval |
| req_line_in | input | 1 | Sensed level of the config-request line |
| done_line_in | input | 1 | Sensed level of the config-done line |
| fast_sel | input | 1 | 1 selects the fast configuration clock rate |
| xfer_done | input | 1 | Data path reports that all configuration data has moved |
| req_pull_low | output | 1 | Pulls the config-request line low |
| status_pull_low | output | 1 | Pulls the status line low |
| done_pull_low | output | 1 | Pulls the config-done line low |
| cclk_tick | output | 1 | Configuration clock enable |
| phase | output | 3 | 0 reset, 1 wait request, 2 configure, 3 wait done, 4 init, 5 error |

## Verification
Boots are run with random reset-interval pins and random rate pins. Comparing the measured interval against both lengths separates a select that is ignored or inverted from a correct one. Random hold-off lengths on the request line, and tick spacing measured while `fast_sel` toggles, expose early entry into configuration and a rate that is not latched. Each boot ends in one of three ways: a clean finish, a held config-done line that must run out the timeout, or power loss in the middle of configuration. Together these separate the error path and the restart path from the normal path.

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq #(
  parameter int POR_SHORT_CYC = 20,
  parameter int POR_LONG_CYC  = 60,
  parameter int DIV_NORMAL    = 4,
  parameter int DIV_FAST      = 2,
  parameter int DONE_TIMEOUT  = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       por_short_sel,
  input  logic       req_line_in,
  input  logic       done_line_in,
  input  logic       fast_sel,
  input  logic       xfer_done,
  output logic       req_pull_low,
  output logic       status_pull_low,
  output logic       done_pull_low,
  output logic       cclk_tick,
  output logic [2:0] phase
);
  localparam int MAX_A = (POR_SHORT_CYC > POR_LONG_CYC) ? POR_SHORT_CYC : POR_LONG_CYC;
  localparam int MAX_C = (MAX_A > DONE_TIMEOUT) ? MAX_A : DONE_TIMEOUT;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam int MAX_D = (DIV_NORMAL > DIV_FAST) ? DIV_NORMAL : DIV_FAST;
  localparam int DW    = $clog2(MAX_D + 1);

  typedef enum logic [2:0] {
    S_POR = 3'd0, S_REQ = 3'd1, S_CFG = 3'd2,
    S_DONE = 3'd3, S_INIT = 3'd4, S_ERR = 3'd5
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dcnt;
  logic sel_q, fast_q;

  wire [CW-1:0] por_lim = sel_q  ? CW'(POR_SHORT_CYC - 1) : CW'(POR_LONG_CYC - 1);
  wire [CW-1:0] to_lim  = CW'(DONE_TIMEOUT - 1);
  wire [DW-1:0] div_lim = fast_q ? DW'(DIV_FAST - 1) : DW'(DIV_NORMAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_POR;
      cnt    <= '0;
      dcnt   <= '0;
      sel_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (!pwr_good) begin
      st   <= S_POR;
      cnt  <= '0;
      dcnt <= '0;
    end else begin
      case (st)
        S_POR: begin
          if (cnt == '0) sel_q <= por_short_sel;
          if (cnt != '0 && cnt == por_lim) begin
            st  <= S_REQ;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REQ: begin
          if (req_line_in) begin
            st     <= S_CFG;
            fast_q <= fast_sel;
            dcnt   <= '0;
          end
        end
        S_CFG: begin
          dcnt <= (dcnt == div_lim) ? '0 : dcnt + 1'b1;
          if (xfer_done) begin
            st  <= S_DONE;
            cnt <= '0;
          end
        end
        S_DONE: begin
          if (done_line_in)       st  <= S_INIT;
          else if (cnt == to_lim) st  <= S_ERR;
          else                    cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase           = st;
  assign req_pull_low    = (st == S_POR);
  assign status_pull_low = (st == S_POR) || (st == S_ERR);
  assign done_pull_low   = (st == S_POR) || (st == S_REQ) || (st == S_CFG);
  assign cclk_tick       = (st == S_CFG) && (dcnt == div_lim);
endmodule

// File: rtl/cfg_phase_seq_chk.sv
module cfg_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       req_line_in,
  input logic       done_line_in,
  input logic       req_pull_low,
  input logic       status_pull_low,
  input logic       done_pull_low,
  input logic       cclk_tick,
  input logic [2:0] phase
);
  a_r1_por_drives: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |-> req_pull_low && status_pull_low && done_pull_low && !cclk_tick);
  a_r3_cfg_entry: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd1 && pwr_good && req_line_in |=> phase == 3'd2);
  a_r4_tick_only_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_tick |-> phase == 3'd2);
  a_r5_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd3 |-> !done_pull_low);
  a_r6_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd4 && pwr_good |=> phase == 3'd4 && !status_pull_low);
  a_r6_init_entry: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd3 && pwr_good && done_line_in |=> phase == 3'd4);
  a_r7_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd5 |-> status_pull_low);
  a_r8_pg_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> phase == 3'd0);
endmodule

bind cfg_phase_seq cfg_phase_seq_chk u_chk (.*);

// File: tb/cfg_phase_seq_test.sv
module cfg_phase_seq_test;
  localparam int PS = 20, PL = 60, DN = 4, DF = 2, TO = 30;

  logic clk = 0, rst_n = 0, pwr_good = 1, por_short_sel = 1, fast_sel = 0, xfer_done = 0;
  logic ext_req_hold = 0, ext_done_hold = 0;
  logic req_pull_low, status_pull_low, done_pull_low, cclk_tick;
  logic [2:0] phase;
  wire req_line_in  = (req_pull_low  || ext_req_hold)  ? 1'b0 : 1'b1;
  wire done_line_in = (done_pull_low || ext_done_hold) ? 1'b0 : 1'b1;

  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  cfg_phase_seq #(.POR_SHORT_CYC(PS), .POR_LONG_CYC(PL), .DIV_NORMAL(DN),
                  .DIV_FAST(DF), .DONE_TIMEOUT(TO)) uut (.*);

  function automatic int exp_por(input logic pin); return pin ? PS : PL; endfunction
  function automatic int exp_div(input logic f);   return f ? DF : DN;   endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entered at a negedge with the block in phase 0, counter cleared
  task automatic run_boot(input logic pin, input logic fast, input int hold, input int mode);
    int n = 0, bad = 0, d;
    chk(phase == 0 && req_pull_low && status_pull_low && done_pull_low && !cclk_tick,
        "R1 por drives", {req_pull_low, status_pull_low, done_pull_low}, 7);
    fast_sel = fast;
    ext_req_hold = (hold > 0);
    ext_done_hold = (mode == 1);
    while (phase == 0 && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp_por(pin), "R2 por length", n, exp_por(pin));
    chk(phase == 1 && !req_pull_low, "R3 req released", phase, 1);
    for (int i = 0; i < hold; i++) begin
      if (phase != 1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R3 held while line low", bad, 0);
    ext_req_hold = 0;
    @(negedge clk);
    chk(phase == 2, "R3 config entry", phase, 2);
    if (mode == 2) begin
      pwr_good = 0;
      @(negedge clk);
      chk(phase == 0 && req_pull_low && status_pull_low, "R8 restart mid config", phase, 0);
      pwr_good = 1;
      return;
    end
    d = exp_div(fast);
    bad = 0;
    for (int k = 0; k < 3 * d + 1; k++) begin
      if (cclk_tick != ((k % d) == d - 1)) bad++;
      if (!done_pull_low) bad++;
      if (k > 0) fast_sel = $urandom_range(0, 1);
      @(negedge clk);
    end
    chk(bad == 0, "R4 R9 tick spacing", bad, 0);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    chk(phase == 3 && !done_pull_low, "R5 done released", phase, 3);
    if (mode == 1) begin
      n = 0;
      while (phase == 3 && n < 1000) begin n++; @(negedge clk); end
      chk(n == TO, "R7 timeout length", n, TO);
      chk(phase == 5 && status_pull_low, "R7 error status", phase, 5);
      ext_done_hold = 0;
    end else begin
      @(negedge clk);
      chk(phase == 4 && !status_pull_low && !cclk_tick, "R6 init entry", phase, 4);
      repeat (3) @(negedge clk);
      chk(phase == 4, "R6 init holds", phase, 4);
    end
  endtask

  task automatic power_cycle(input logic pin);
    pwr_good = 0;
    @(negedge clk);
    chk(phase == 0 && req_pull_low && status_pull_low && done_pull_low, "R8 pg low", phase, 0);
    por_short_sel = pin;
    pwr_good = 1;
  endtask

  initial begin
    logic pin;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(phase == 0 && status_pull_low, "R1 reset state", phase, 0);
    por_short_sel = 1;
    rst_n = 1;
    run_boot(1'b1, 1'b0, 0, 0);
    power_cycle(1'b0);
    run_boot(1'b0, 1'b1, 3, 1);
    power_cycle(1'b1);
    run_boot(1'b1, 1'b1, 1, 2);
    power_cycle(1'b1);
    repeat (5) @(negedge clk);
    power_cycle(1'b0);
    run_boot(1'b0, 1'b0, 0, 0);
    for (int it = 0; it < 8; it++) begin
      pin = $urandom_range(0, 1);
      power_cycle(pin);
      run_boot(pin, 1'($urandom_range(0, 1)), $urandom_range(0, 6), $urandom_range(0, 2));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule